// File: doc/BRIEF.md
# Link Error Attention Aggregator

This block gathers link-layer error activity into a single attention output. Four event counters track receive-side error classes: malformed transaction packets, out-of-order sequence numbers, corrupted link packets and received negative acknowledgements. Each counter has its own threshold. When a counter reaches its threshold, it latches an attention bit. A fifth attention bit summarises six sticky link status flags: flow-control update timeout, flow-control receive overflow, flow-control protocol error, link protocol error, replay rollover and replay timeout.

Software sees the block through a simple read/write register port with combinational read data. Reading a counter returns its value. On the following edge, the read clears that counter and its attention bit. Reading the status register clears the status flags, and with them the summary bit. A mask register selects which attention bits may drive the output. The output is the OR of the enabled attention bits, registered once.

Top module: `link_attn_agg`

## Requirements
- R1: Address 5 reads the attention vector. Bit 0 belongs to the malformed-packet counter, bit 1 to the bad-sequence counter, bit 2 to the corrupted-link-packet counter, bit 3 to the NAK counter, and bit 4 is the status summary. Bits 31:5 read as 0, and reading this address has no side effect.
- R2: Each pulse on `evt_strobe[i]` adds one to counter i. Address i (0 to 3) returns that count in bits 15:0, with bits 31:16 zero.
- R3: Attention bit i (0 to 3) is set, and stays set, once counter i is greater than or equal to threshold i, taken from `attn_thresh[16*i +: 16]`. A threshold of 0 never sets the bit.
- R4: Reading address i clears counter i and attention bit i on the next edge. If `evt_strobe[i]` is high in that same cycle, the counter restarts at 1.
- R5: A counter saturates at 65535 and does not wrap.
- R6: Each pulse on `status_set[j]` sets sticky status flag j. Address 4 returns the flags in bits 5:0. Attention bit 4 is high while any flag is set.
- R7: Reading address 4 clears all status flags on the next edge. A flag whose `status_set` bit is high in that cycle stays set.
- R8: Address 6 is an 8-bit read/write mask, and bits 31:8 read as 0. Writes to any other address have no effect.
- R9: `attn_out` is high one cycle after any attention bit 4:0 is high together with its mask bit. Mask bits 7:5 have no effect on the output.
- R10: After reset, all counters, attention bits, status flags, mask bits and `attn_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | 4 | Single-cycle error event pulses, one per counter |
| status_set | input | 6 | Single-cycle pulses that set the sticky status flags |
| attn_thresh | input | 64 | Four 16-bit attention thresholds; 0 disables that bit |
| reg_rd | input | 1 | Register read strobe; its side effects apply on the edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data; only the mask register accepts it |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| attn_out | output | 1 | Registered, masked attention output |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high in the same cycle, and that `reg_addr` stays within 0 to 6 whenever either strobe is high. The clear-on-read properties also assume that a read lasts exactly one cycle, because a held read would clear the counter again. The bench issues every access as a one-cycle pulse driven on the falling edge, never combines a read with a write, and uses only the seven defined addresses. Thresholds change only while no events are arriving.

// File: rtl/lea_pkg.sv
package lea_pkg;
    localparam int CNT_W_DEF  = 16;
    localparam int N_CNT_DEF  = 4;
    localparam int N_STAT_DEF = 6;
    localparam int MASK_W_DEF = 8;
    localparam int DATA_W_DEF = 32;

    function automatic int addr_width(input int n_cnt);
        return $clog2(n_cnt + 3);
    endfunction
endpackage

// File: rtl/lea_evt_counter.sv
module lea_evt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clr,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] count,
    output logic             attn
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             attn;
    } ctr_t;

    ctr_t st_d, st_q;
    logic hit;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = evt ? CNT_W'(1) : '0;
        end else if (evt && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        hit = (thresh != '0) && (st_d.cnt >= thresh);
        if (clr) begin
            st_d.attn = 1'b0;
        end else begin
            st_d.attn = st_q.attn | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign attn  = st_q.attn;
endmodule

// File: rtl/lea_status_flags.sv
module lea_status_flags #(
    parameter int N_STAT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_STAT-1:0] set,
    input  logic              clr,
    output logic [N_STAT-1:0] flags,
    output logic              any
);
    typedef struct packed {
        logic [N_STAT-1:0] flags;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.flags = set;
        end else begin
            st_d.flags = st_q.flags | set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;
    assign any   = |st_q.flags;
endmodule

// File: rtl/lea_reg_decode.sv
module lea_reg_decode #(
    parameter int N_CNT  = 4,
    parameter int CNT_W  = 16,
    parameter int N_STAT = 6,
    parameter int MASK_W = 8,
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32
) (
    input  logic                   reg_rd,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [N_CNT*CNT_W-1:0] cnt_flat,
    input  logic [N_STAT-1:0]      flags,
    input  logic [N_CNT:0]         attn_vec,
    input  logic [MASK_W-1:0]      mask,
    output logic [N_CNT-1:0]       cnt_clr,
    output logic                   stat_clr,
    output logic                   mask_we,
    output logic [DATA_W-1:0]      rdata
);
    localparam int STAT_ADDR = N_CNT;
    localparam int ATTN_ADDR = N_CNT + 1;
    localparam int MASK_ADDR = N_CNT + 2;

    int addr_i;

    always_comb begin
        addr_i   = int'(reg_addr);
        rdata    = '0;
        cnt_clr  = '0;
        stat_clr = reg_rd && (addr_i == STAT_ADDR);
        mask_we  = reg_wr && (addr_i == MASK_ADDR);
        for (int i = 0; i < N_CNT; i++) begin
            if (addr_i == i) begin
                rdata      = DATA_W'(cnt_flat[i*CNT_W +: CNT_W]);
                cnt_clr[i] = reg_rd;
            end
        end
        if (addr_i == STAT_ADDR) rdata = DATA_W'(flags);
        if (addr_i == ATTN_ADDR) rdata = DATA_W'(attn_vec);
        if (addr_i == MASK_ADDR) rdata = DATA_W'(mask);
    end
endmodule

// File: rtl/link_attn_agg.sv
module link_attn_agg #(
    parameter int CNT_W  = lea_pkg::CNT_W_DEF,
    parameter int N_CNT  = lea_pkg::N_CNT_DEF,
    parameter int N_STAT = lea_pkg::N_STAT_DEF,
    parameter int MASK_W = lea_pkg::MASK_W_DEF,
    parameter int DATA_W = lea_pkg::DATA_W_DEF,
    parameter int ADDR_W = lea_pkg::addr_width(N_CNT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CNT-1:0]       evt_strobe,
    input  logic [N_STAT-1:0]      status_set,
    input  logic [N_CNT*CNT_W-1:0] attn_thresh,
    input  logic                   reg_rd,
    input  logic                   reg_wr,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic [MASK_W-1:0]      reg_wdata,
    output logic [DATA_W-1:0]      reg_rdata,
    output logic                   attn_out
);
    localparam int ATTN_W = N_CNT + 1;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              out;
    } top_t;

    top_t st_d, st_q;

    logic [N_CNT*CNT_W-1:0] cnt_flat;
    logic [N_CNT-1:0]       cnt_attn;
    logic [N_CNT-1:0]       cnt_clr;
    logic [N_STAT-1:0]      stat_flags;
    logic                   stat_any;
    logic                   stat_clr;
    logic                   mask_we;
    logic [ATTN_W-1:0]      attn_vec;
    logic [MASK_W-1:0]      mask_q;

    for (genvar g = 0; g < N_CNT; g++) begin : g_ctr
        lea_evt_counter #(.CNT_W(CNT_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_strobe[g]),
            .clr    (cnt_clr[g]),
            .thresh (attn_thresh[g*CNT_W +: CNT_W]),
            .count  (cnt_flat[g*CNT_W +: CNT_W]),
            .attn   (cnt_attn[g])
        );
    end

    lea_status_flags #(.N_STAT(N_STAT)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (status_set),
        .clr   (stat_clr),
        .flags (stat_flags),
        .any   (stat_any)
    );

    assign attn_vec = {stat_any, cnt_attn};
    assign mask_q   = st_q.mask;

    lea_reg_decode #(
        .N_CNT  (N_CNT),
        .CNT_W  (CNT_W),
        .N_STAT (N_STAT),
        .MASK_W (MASK_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .reg_rd   (reg_rd),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .cnt_flat (cnt_flat),
        .flags    (stat_flags),
        .attn_vec (attn_vec),
        .mask     (st_q.mask),
        .cnt_clr  (cnt_clr),
        .stat_clr (stat_clr),
        .mask_we  (mask_we),
        .rdata    (reg_rdata)
    );

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.mask = reg_wdata;
        end
        st_d.out = |(attn_vec & st_q.mask[ATTN_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign attn_out = st_q.out;
endmodule

// File: rtl/lea_checker.sv
module lea_checker #(
    parameter int CNT_W  = 16,
    parameter int N_CNT  = 4,
    parameter int N_STAT = 6,
    parameter int MASK_W = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_CNT-1:0]       evt_strobe,
    input logic [N_STAT-1:0]      status_set,
    input logic                   reg_rd,
    input logic                   reg_wr,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [MASK_W-1:0]      reg_wdata,
    input logic [DATA_W-1:0]      reg_rdata,
    input logic                   attn_out,
    input logic [N_CNT*CNT_W-1:0] cnt_flat,
    input logic [N_STAT-1:0]      stat_flags,
    input logic [N_CNT:0]         attn_vec,
    input logic [MASK_W-1:0]      mask_q
);
    localparam int ATTN_W = N_CNT + 1;
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(N_CNT);
    localparam logic [ADDR_W-1:0] ATTN_A = ADDR_W'(N_CNT + 1);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(N_CNT + 2);
    localparam logic [CNT_W-1:0]  CMAX   = '1;

    a_in_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr));

    // R1: upper bits of the attention register are zero
    a_r1_attn_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ATTN_A) |-> (reg_rdata[DATA_W-1:ATTN_W] == '0));

    for (genvar i = 0; i < N_CNT; i++) begin : g_cnt_chk
        // R4: read without an event empties the counter
        a_r4_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && reg_addr == ADDR_W'(i) && !evt_strobe[i])
            |=> (cnt_flat[i*CNT_W +: CNT_W] == '0));
        // R4: read with an event restarts at one
        a_r4_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && reg_addr == ADDR_W'(i) && evt_strobe[i])
            |=> (cnt_flat[i*CNT_W +: CNT_W] == CNT_W'(1)));
        // R4: the attention bit drops with the read
        a_r4_attn_cleared: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_rd && reg_addr == ADDR_W'(i)) |=> !attn_vec[i]);
        // R5: saturation
        a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_flat[i*CNT_W +: CNT_W] == CMAX && evt_strobe[i]
             && !(reg_rd && reg_addr == ADDR_W'(i)))
            |=> (cnt_flat[i*CNT_W +: CNT_W] == CMAX));
    end

    for (genvar j = 0; j < N_STAT; j++) begin : g_stat_chk
        // R7: a set pulse always wins over the clearing read
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            status_set[j] |=> stat_flags[j]);
    end

    // R7: status read clears every flag when no set pulse is present
    a_r7_status_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == STAT_A && status_set == '0) |=> (stat_flags == '0));

    // R8: a mask write lands on the next edge
    a_r8_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == MASK_A) |=> (mask_q == $past(reg_wdata)));

    // R8: the mask holds without a write to it
    a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == MASK_A) |=> $stable(mask_q));

    // R9: the output follows the enabled attention bits one cycle later
    a_r9_out_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((attn_vec & mask_q[ATTN_W-1:0]) != '0) |=> attn_out);
    a_r9_out_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((attn_vec & mask_q[ATTN_W-1:0]) == '0) |=> !attn_out);
endmodule

bind link_attn_agg lea_checker #(
    .CNT_W  (CNT_W),
    .N_CNT  (N_CNT),
    .N_STAT (N_STAT),
    .MASK_W (MASK_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_strobe (evt_strobe),
    .status_set (status_set),
    .reg_rd     (reg_rd),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .attn_out   (attn_out),
    .cnt_flat   (cnt_flat),
    .stat_flags (stat_flags),
    .attn_vec   (attn_vec),
    .mask_q     (mask_q)
);

// File: tb/link_attn_agg_bench.sv
module link_attn_agg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  evt_strobe = '0;
    logic [5:0]  status_set = '0;
    logic [63:0] attn_thresh = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        attn_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    link_attn_agg u_link_attn_agg (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_strobe  (evt_strobe),
        .status_set  (status_set),
        .attn_thresh (attn_thresh),
        .reg_rd      (reg_rd),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .attn_out    (attn_out)
    );

    typedef struct packed {
        logic [3:0]  evt;
        logic [5:0]  stat;
        logic        rd;
        logic        wr;
        logic [2:0]  addr;
        logic [7:0]  wd;
        logic [31:0] exp;
        logic        exp_out;
    } vec_t;

    // thresholds: ctr0=3, ctr1=1, ctr2=0 (off), ctr3=2
    localparam vec_t VEC [32] = '{
        '{4'h0, 6'h00, 1'b0, 1'b1, 3'd6, 8'h1F, 32'h00, 1'b0},  // R8 mask write
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd6, 8'h00, 32'h1F, 1'b0},  // R8 mask read
        '{4'h1, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00, 32'h00, 1'b0},  // R2
        '{4'h1, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00, 32'h00, 1'b0},
        '{4'h1, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00, 32'h00, 1'b0},  // R3 reaches 3
        '{4'h0, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00, 32'h00, 1'b0},  // R9 one-cycle lag
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd5, 8'h00, 32'h01, 1'b1},  // R1
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd0, 8'h00, 32'h03, 1'b1},  // R2 read count
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd5, 8'h00, 32'h00, 1'b1},  // R4 attn cleared
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd0, 8'h00, 32'h00, 1'b0},  // R4 count cleared
        '{4'h2, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00, 32'h00, 1'b0},
        '{4'h4, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00, 32'h00, 1'b0},
        '{4'h4, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00, 32'h00, 1'b1},
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd5, 8'h00, 32'h02, 1'b1},  // R3 thr 0 disabled
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd2, 8'h00, 32'h02, 1'b1},
        '{4'h2, 6'h00, 1'b1, 1'b0, 3'd1, 8'h00, 32'h01, 1'b1},  // R4 read + event
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd1, 8'h00, 32'h01, 1'b1},  // R4 restarted at 1
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd5, 8'h00, 32'h00, 1'b0},
        '{4'h0, 6'h04, 1'b0, 1'b0, 3'd0, 8'h00, 32'h00, 1'b0},  // R6 set flag
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd5, 8'h00, 32'h10, 1'b0},  // R6 summary bit
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd4, 8'h00, 32'h04, 1'b1},  // R6 flags read
        '{4'h0, 6'h20, 1'b1, 1'b0, 3'd4, 8'h00, 32'h00, 1'b1},  // R7 set wins
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd4, 8'h00, 32'h20, 1'b0},
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd4, 8'h00, 32'h00, 1'b1},  // R7 cleared
        '{4'h0, 6'h00, 1'b0, 1'b1, 3'd6, 8'hE0, 32'h00, 1'b0},  // R9 reserved mask
        '{4'h8, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00, 32'h00, 1'b0},
        '{4'h8, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00, 32'h00, 1'b0},
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd5, 8'h00, 32'h08, 1'b0},  // R9 no output
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd6, 8'h00, 32'hE0, 1'b0},
        '{4'h0, 6'h00, 1'b0, 1'b1, 3'd3, 8'hFF, 32'h00, 1'b0},  // R8 write elsewhere
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd3, 8'h00, 32'h02, 1'b0},  // R8 ignored
        '{4'h0, 6'h00, 1'b1, 1'b0, 3'd6, 8'h00, 32'hE0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] e, input logic [5:0] s, input logic rd,
                         input logic wr, input logic [2:0] a, input logic [7:0] wd);
        @(negedge clk);
        evt_strobe = e;
        status_set = s;
        reg_rd = rd;
        reg_wr = wr;
        reg_addr = a;
        reg_wdata = wd;
        #1;
    endtask

    task automatic idle();
        drive(4'h0, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle();
        idle();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        attn_thresh = {16'd2, 16'd0, 16'd1, 16'd3};
        do_reset();

        // R10 reset state
        drive(4'h0, 6'h00, 1'b0, 1'b0, 3'd5, 8'h00);
        chk("R10 attention reg", reg_rdata, 32'h0);
        chk("R10 attn_out", {31'h0, attn_out}, 32'h0);
        drive(4'h0, 6'h00, 1'b0, 1'b0, 3'd6, 8'h00);
        chk("R10 mask reg", reg_rdata, 32'h0);
        drive(4'h0, 6'h00, 1'b0, 1'b0, 3'd4, 8'h00);
        chk("R10 status reg", reg_rdata, 32'h0);
        for (int i = 0; i < 4; i++) begin
            drive(4'h0, 6'h00, 1'b0, 1'b0, 3'(i), 8'h00);
            chk("R10 counter", reg_rdata, 32'h0);
        end

        // vector table
        for (int v = 0; v < 32; v++) begin
            drive(VEC[v].evt, VEC[v].stat, VEC[v].rd, VEC[v].wr, VEC[v].addr, VEC[v].wd);
            if (VEC[v].rd) chk($sformatf("R1-R9 vector %0d rdata", v), reg_rdata, VEC[v].exp);
            chk($sformatf("R9 vector %0d attn_out", v), {31'h0, attn_out}, {31'h0, VEC[v].exp_out});
        end

        // R5 saturation: 65537 events on counter 0
        for (int k = 0; k < 65537; k++) drive(4'h1, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00);
        drive(4'h0, 6'h00, 1'b1, 1'b0, 3'd0, 8'h00);
        chk("R5 saturated count", reg_rdata, 32'h0000FFFF);
        drive(4'h0, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00);
        chk("R4 cleared after saturation", reg_rdata, 32'h0);

        // R3 zero threshold disables bit 0
        attn_thresh[15:0] = 16'd0;
        drive(4'h0, 6'h00, 1'b0, 1'b1, 3'd6, 8'h1F);
        for (int k = 0; k < 5; k++) drive(4'h1, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00);
        idle();
        idle();
        drive(4'h0, 6'h00, 1'b0, 1'b0, 3'd5, 8'h00);
        chk("R3 zero threshold attention", reg_rdata, 32'h0);
        chk("R3 zero threshold attn_out", {31'h0, attn_out}, 32'h0);
        drive(4'h0, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00);
        chk("R2 count with threshold off", reg_rdata, 32'd5);

        // R10 reset clears mask and counter
        do_reset();
        drive(4'h0, 6'h00, 1'b0, 1'b0, 3'd6, 8'h00);
        chk("R10 mask after re-reset", reg_rdata, 32'h0);
        drive(4'h0, 6'h00, 1'b0, 1'b0, 3'd0, 8'h00);
        chk("R10 counter after re-reset", reg_rdata, 32'h0);

        idle();
        finish_run();
    end
endmodule